// File: doc/BRIEF.md
# Signed Radix-4 Multiplier with Sign-Magnitude Rows and Carry-Free Accumulation

This block multiplies two signed two's-complement operands of `W` bits and returns the full `2W`-bit signed product. The first operand (the multiplicand) is split into a sign and a ones'-complement magnitude. The missing "+1" of that magnitude is gathered into one sparse correction row. The second operand (the multiplier) stays in two's complement and is scanned in overlapping three-bit groups by a radix-4 Booth recoder. Negating a row only flips its sign, so no row has to be complemented bit by bit. Each row's magnitude bits are paired with its sign to form signed digits in {-1, 0, +1}, which needs nothing but wiring.

All rows, including the correction row, are summed by a binary tree of carry-free signed-digit adders. Each adder reduces two operands to one. When a tree level has an odd row count, the odd row passes to the next level unchanged. The digit sum is optionally registered. It is then turned back into two's complement by subtracting the number made of the negative digits from the number made of the positive digits. Digits above `2W` are discarded.

Data moves on a valid/ready stream. An input transfer happens on a rising edge where `in_valid` and `in_ready` are both high, and an output transfer happens where `out_valid` and `out_ready` are both high. With the register stage present (`PIPE`=1), `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the block holds its result and refuses new inputs. Without the stage (`PIPE`=0), the block is combinational from the inputs to the outputs, with `out_valid` equal to `in_valid` and `in_ready` equal to `out_ready`.

Top module: `mixrep_mult`

## Requirements
- R1: `out_prod` equals the signed product of `in_a` and `in_b` as a `2W`-bit two's-complement value for every operand pair, including the most negative value times itself (for W=8, -128 x -128 = 0x4000).
- R2: A negative multiplicand is handled as sign plus ones'-complement magnitude, with the missing +1 per row supplied by a correction row. Products with a negative `in_a`, including -2^(W-1), are exact.
- R3: The multiplier is recoded as radix-4 Booth digits in {-2..+2} from the bit groups (2k+1, 2k, 2k-1), with bit -1 taken as 0 and with sign extension when W is odd. Multipliers such as all ones, 0x80 and alternating 01/10 patterns give exact products.
- R4: Every digit produced by every carry-free adder is in {-1, 0, +1}. A digit is encoded as a (positive, negative) bit pair that never has both bits set, and no adder position ever receives a transfer that would push its digit to +/-2.
- R5: The result equals the positive-digit number minus the negative-digit number, taken modulo 2^(2W).
- R6: With `PIPE`=1, an accepted input gives `out_valid` high on the next rising edge.
- R7: With `PIPE`=1, `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_prod` keep their values on the next edge.
- R8: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R9: A cycle with no accepted input and a drained output leaves `out_valid` low on the next edge. No result appears that was not requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | W | Multiplicand, two's complement |
| in_b | input | W | Multiplier, two's complement |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_prod | output | 2W | Signed product, two's complement |

## Verification
A wrong Booth decode, a misplaced correction digit or a bad carry-free transfer rule corrupts only certain operand combinations. Such a fault shows on `out_prod` on the very transfer that carries those operands, one cycle after acceptance. That is why every operand pair for W=8 is applied, each compared with a signed multiply, with random gaps on both valid and ready. A broken hold or ready rule shows within one stalled cycle, as a changed product or a lost or duplicated result in the ordered scoreboard.

// File: rtl/mixrep_pkg.sv
package mixrep_pkg;

  // rows left after a given number of pairwise reduction levels
  function automatic int unsigned rows_at_level(int unsigned rows, int unsigned lvl);
    int unsigned r;
    r = rows;
    for (int unsigned i = 0; i < lvl; i++) r = (r + 1) / 2;
    return r;
  endfunction

  // pairwise levels needed to reach a single row
  function automatic int unsigned levels_for(int unsigned rows);
    int unsigned r;
    int unsigned d;
    r = rows;
    d = 0;
    for (int i = 0; i < 32; i++) begin
      if (r > 1) begin
        r = (r + 1) / 2;
        d++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/mixrep_sm_conv.sv
module mixrep_sm_conv #(
  parameter int W = 8
) (
  input  logic [W-1:0] y,
  output logic         y_sign,
  output logic [W-2:0] y_mag_lo
);
  // magnitude kept in ones' complement; the +1 is carried by a correction row
  assign y_sign   = y[W-1];
  assign y_mag_lo = y[W-2:0] ^ {(W-1){y[W-1]}};
endmodule

// File: rtl/mixrep_ppgen.sv
module mixrep_ppgen #(
  parameter int W   = 8,
  parameter int NPP = (W + 1) / 2,
  parameter int PW  = 2 * W
) (
  input  logic [W-1:0]  x,
  input  logic          y_sign,
  input  logic [W-2:0]  y_mag_lo,
  output logic [PW-1:0] row_pos [NPP+1],
  output logic [PW-1:0] row_neg [NPP+1]
);
  localparam int XW = 2 * NPP + 1;

  logic [XW-1:0] xe;
  logic [NPP-1:0] one_v, two_v, rsg_v;

  always_comb begin
    xe = '0;
    xe[W:1] = x;
    for (int i = W + 1; i < XW; i++) xe[i] = x[W-1];
  end

  for (genvar k = 0; k < NPP; k++) begin : g_row
    logic b0, b1, b2, negd;
    logic [W-1:0]  mag_sel;
    logic [PW-1:0] shifted;
    assign b0 = xe[2*k];
    assign b1 = xe[2*k+1];
    assign b2 = xe[2*k+2];
    assign one_v[k] = b1 ^ b0;
    assign two_v[k] = (b2 & ~b1 & ~b0) | (~b2 & b1 & b0);
    assign negd     = b2 & ~(b1 & b0);
    assign rsg_v[k] = y_sign ^ negd;
    assign mag_sel  = one_v[k] ? {1'b0, y_mag_lo} :
                      two_v[k] ? {y_mag_lo, 1'b0} : '0;
    assign shifted  = PW'(mag_sel) << (2 * k);
    // sign-magnitude row becomes signed digits by pairing each bit with the sign
    assign row_pos[k] = shifted & {PW{~rsg_v[k]}};
    assign row_neg[k] = shifted & {PW{rsg_v[k]}};
  end

  // correction row: the +1 of each row's ones'-complement magnitude
  always_comb begin
    row_pos[NPP] = '0;
    row_neg[NPP] = '0;
    for (int k = 0; k < NPP; k++) begin
      if (y_sign && (one_v[k] || two_v[k])) begin
        if (rsg_v[k]) row_neg[NPP][2*k + int'(two_v[k])] = 1'b1;
        else          row_pos[NPP][2*k + int'(two_v[k])] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mixrep_rbadd.sv
module mixrep_rbadd #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] a_pos,
  input  logic [PW-1:0] a_neg,
  input  logic [PW-1:0] b_pos,
  input  logic [PW-1:0] b_neg,
  output logic [PW-1:0] s_pos,
  output logic [PW-1:0] s_neg
);
  logic [PW-1:0] mid_p, mid_n, tr_p, tr_n;
  logic [PW-1:0] nonneg, low_nn, ci_p, ci_n;

  assign nonneg = ~(a_neg | b_neg);
  assign low_nn = {nonneg[PW-2:0], 1'b1};

  always_comb begin
    mid_p = '0;
    mid_n = '0;
    tr_p  = '0;
    tr_n  = '0;
    for (int i = 0; i < PW; i++) begin
      int dsum;
      dsum = int'(a_pos[i]) - int'(a_neg[i]) + int'(b_pos[i]) - int'(b_neg[i]);
      case (dsum)
        2:  tr_p[i] = 1'b1;
        -2: tr_n[i] = 1'b1;
        1: begin
          if (low_nn[i]) begin tr_p[i] = 1'b1; mid_n[i] = 1'b1; end
          else                 mid_p[i] = 1'b1;
        end
        -1: begin
          if (low_nn[i])       mid_n[i] = 1'b1;
          else begin tr_n[i] = 1'b1; mid_p[i] = 1'b1; end
        end
        default: ;
      endcase
    end
  end

  assign ci_p = {tr_p[PW-2:0], 1'b0};
  assign ci_n = {tr_n[PW-2:0], 1'b0};

  assign s_pos = (mid_p & ~ci_p & ~ci_n) | (~mid_p & ~mid_n & ci_p);
  assign s_neg = (mid_n & ~ci_p & ~ci_n) | (~mid_p & ~mid_n & ci_n);

  always_comb begin
    AST_DIGIT_BOUND: assert (((mid_p & ci_p) | (mid_n & ci_n)) == '0); // R4
  end
endmodule

// File: rtl/mixrep_mult.sv
module mixrep_mult #(
  parameter int W    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2*W-1:0] out_prod
);
  import mixrep_pkg::*;

  localparam int PW    = 2 * W;
  localparam int NPP   = (W + 1) / 2;
  localparam int ROWS  = NPP + 1;
  localparam int DEPTH = levels_for(ROWS);

  logic          y_sign;
  logic [W-2:0]  y_mag_lo;
  logic [PW-1:0] pp_pos [ROWS];
  logic [PW-1:0] pp_neg [ROWS];
  logic [PW-1:0] tp [DEPTH+1][ROWS];
  logic [PW-1:0] tn [DEPTH+1][ROWS];
  logic [PW-1:0] fin_pos, fin_neg;

  mixrep_sm_conv #(.W(W)) u_sm (
    .y(in_a), .y_sign(y_sign), .y_mag_lo(y_mag_lo)
  );

  mixrep_ppgen #(.W(W), .NPP(NPP), .PW(PW)) u_pp (
    .x(in_b), .y_sign(y_sign), .y_mag_lo(y_mag_lo),
    .row_pos(pp_pos), .row_neg(pp_neg)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_l0
    assign tp[0][r] = pp_pos[r];
    assign tn[0][r] = pp_neg[r];
  end

  for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
    localparam int CNT = rows_at_level(ROWS, l);
    for (genvar j = 0; j < ROWS; j++) begin : g_node
      if (2 * j + 1 < CNT) begin : g_add
        mixrep_rbadd #(.PW(PW)) u_add (
          .a_pos(tp[l][2*j]),   .a_neg(tn[l][2*j]),
          .b_pos(tp[l][2*j+1]), .b_neg(tn[l][2*j+1]),
          .s_pos(tp[l+1][j]),   .s_neg(tn[l+1][j])
        );
      end else if (2 * j < CNT) begin : g_pass
        assign tp[l+1][j] = tp[l][2*j];
        assign tn[l+1][j] = tn[l][2*j];
      end else begin : g_zero
        assign tp[l+1][j] = '0;
        assign tn[l+1][j] = '0;
      end
    end
  end

  if (PIPE) begin : g_reg
    logic          vld_q;
    logic [PW-1:0] pos_q, neg_q;

    assign in_ready = ~vld_q | out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        pos_q <= '0;
        neg_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          pos_q <= tp[DEPTH][0];
          neg_q <= tn[DEPTH][0];
        end
      end
    end

    assign out_valid = vld_q;
    assign fin_pos   = pos_q;
    assign fin_neg   = neg_q;

    AST_CLEAN_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> ((pos_q & neg_q) == '0)); // R4
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_prod))); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_ready) |=> !out_valid); // R9
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign fin_pos   = tp[DEPTH][0];
    assign fin_neg   = tn[DEPTH][0];
  end

  // positive-digit number minus negative-digit number, modulo 2^PW
  assign out_prod = fin_pos - fin_neg;

  always_comb begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!PIPE || (!out_valid && in_ready)); // R8
    end
  end
endmodule

// File: tb/mixrep_mult_bench.sv
`timescale 1ns/1ps
module mixrep_mult_bench;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [PW-1:0] out_prod;

  int checks = 0;
  int fails  = 0;
  logic [PW-1:0] exp_q[$];
  string         tag_q[$];
  bit            stall_pend = 1'b0;
  logic [PW-1:0] held_prod;
  bit            finished = 1'b0;

  always #2.5 clk = ~clk;

  mixrep_mult #(.W(W), .PIPE(1'b1)) u_mixrep_mult (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod)
  );

  function automatic logic [PW-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [PW-1:0] sa, sb;
    sa = PW'($signed(a));
    sb = PW'($signed(b));
    return PW'(sa * sb);
  endfunction

  task automatic check(bit ok, string req, logic [PW-1:0] act, logic [PW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // one cycle: drive at the falling edge, observe before the next rising edge
  task automatic cycle(bit iv, logic [W-1:0] a, logic [W-1:0] b, bit ordy,
                       string tag, output bit acc);
    @(negedge clk);
    in_valid  = iv;
    in_a      = a;
    in_b      = b;
    out_ready = ordy;
    #0.5;
    if (stall_pend) begin
      check(out_valid == 1'b1, "R7 stalled valid held", PW'(out_valid), PW'(1));
      check(out_prod == held_prod, "R7 stalled product held", out_prod, held_prod);
      stall_pend = 1'b0;
    end
    check(in_ready == (!out_valid || out_ready), "R7 ready rule", PW'(in_ready),
          PW'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unrequested result", out_prod, '0);
      end else begin
        logic [PW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_prod == e, t, out_prod, e);
      end
    end
    if (out_valid && !out_ready) begin
      stall_pend = 1'b1;
      held_prod  = out_prod;
    end
    acc = iv && in_ready;
    if (acc) begin
      exp_q.push_back(ref_prod(a, b));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(logic [W-1:0] a, logic [W-1:0] b, string tag);
    bit acc;
    bit iv;
    acc = 1'b0;
    while (!acc) begin
      iv = ($urandom % 8) != 0;
      cycle(iv, a, b, ($urandom % 8) != 0, tag, acc);
      if (!iv) acc = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin : main
    bit acc;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #0.5;
    check(out_valid == 1'b0, "R8 reset out_valid", PW'(out_valid), PW'(0));
    check(in_ready == 1'b1, "R8 reset in_ready", PW'(in_ready), PW'(1));
    @(negedge clk);
    rst_n = 1'b1;

    // R6: one accepted input shows up on the next edge
    cycle(1'b1, 8'h80, 8'h80, 1'b1, "R1 most negative squared", acc);
    check(acc == 1'b1, "R6 first input accepted", PW'(acc), PW'(1));
    cycle(1'b0, '0, '0, 1'b1, "idle", acc);
    check(out_valid == 1'b1, "R6 valid one cycle after accept", PW'(out_valid), PW'(1));
    // R9: nothing accepted, output drained -> no valid next
    cycle(1'b0, '0, '0, 1'b1, "idle", acc);
    check(out_valid == 1'b0, "R9 no spurious valid", PW'(out_valid), PW'(0));

    // R7: forced stall for several cycles
    cycle(1'b1, 8'h7F, 8'h81, 1'b0, "R7 product after stall", acc);
    cycle(1'b1, 8'h12, 8'h34, 1'b0, "R7 second", acc);
    check(acc == 1'b0, "R7 input refused while stalled", PW'(acc), PW'(0));
    cycle(1'b1, 8'h12, 8'h34, 1'b0, "R7 second", acc);
    cycle(1'b1, 8'h12, 8'h34, 1'b1, "R7 second after release", acc);
    check(acc == 1'b1, "R7 input taken when drained", PW'(acc), PW'(1));

    // directed corners
    send(8'h80, 8'h7F, "R2 most negative multiplicand");
    send(8'hFF, 8'h80, "R2 minus one times most negative");
    send(8'h81, 8'h55, "R2 R3 negative times 0101 pattern");
    send(8'h6D, 8'hAA, "R3 alternating multiplier");
    send(8'h6D, 8'hFF, "R3 multiplier all ones");
    send(8'h6D, 8'h80, "R3 multiplier most negative");
    send(8'h00, 8'h80, "R5 zero multiplicand");
    send(8'hC3, 8'h00, "R5 zero multiplier");
    send(8'h7F, 8'h7F, "R1 largest positive squared");

    // exhaustive sweep with random gaps on both sides
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        send(W'(a), W'(b), "R1 R4 R5 sweep");
      end
    end

    for (int i = 0; i < 20 && exp_q.size() != 0; i++)
      cycle(1'b0, '0, '0, 1'b1, "drain", acc);
    check(exp_q.size() == 0, "R9 all results delivered", PW'(exp_q.size()), '0);
    finish_run();
  end
endmodule